// File: doc/BRIEF.md
# Service-Bus Slave Address Decoder

This block is the slave end of a 32-bit register bus. It splits a 2 MiB byte-address window into three regions. The first region is a read-only configuration table that describes the engines present. The second is a slave-control region that is passed through to a sub-port. The third is a local-bus region, whose first word is a scratchpad register. Every access is a full 32-bit word, and bit 31 of a data word is its most significant byte.

A request is accepted when `req_valid` and `req_ready` are both high. Exactly one cycle later, `rsp_valid` pulses with the read data. Writes return zero data. Writing a special break value to either of the first two configuration words raises `lbus_rst` for one clock. That pulse resets everything on the local bus, including the scratchpad. Addresses that map to nothing read as zero and ignore writes.

Top module: `svc_slave_decoder`

## Requirements
- R1: While `rst` is high, `req_ready`, `rsp_valid` and `lbus_rst` are 0. After reset is released, `req_ready` is 1 and the scratchpad reads 0.
- R2: Every accepted transfer produces `rsp_valid` high in the next cycle only. A cycle with no accepted transfer produces no response. A write response carries `rsp_rdata` = 0.
- R3: A read of byte address 0x000 returns the chip identifier 0xC0022D15.
- R4: Engine descriptor words are laid out as follows: bit 31 = 1 (another entry follows), slot field 0x00010000, a version value ORed in, type in bits 7:4, check value in bits 3:0. Address 0x004 reads 0x8001102C (type 2, version 0x1000, check 0xC). Address 0x008 reads 0x8001503A (type 3, version 0x5000, check 0xA). Address 0x00C reads 0x80011067 (type 6, version 0x1000, check 0x7).
- R5: Configuration addresses 0x010 to 0x3FC read 0. Writes into the configuration table never change what it reads.
- R6: A write of exactly 0xC0DE0000 to address 0x000 or 0x004 drives `lbus_rst` high in the cycle after acceptance, for one cycle. Any other value, or any other address, produces no pulse.
- R7: The scratchpad at address 0xC00 is a read/write 32-bit register. The cycle in which `lbus_rst` is high clears it to 0, and that clear wins over a scratchpad write captured in the same cycle.
- R8: An aligned access to 0x800 to 0xBFC drives `ctl_valid` combinationally in the accepting cycle. It carries `ctl_addr` = address − 0x800 and passes `ctl_write` and `ctl_wdata` through. A read returns the `ctl_rdata` sampled in that cycle. `ctl_valid` is 0 for every other access.
- R9: Addresses 0x400 to 0x7FC, and local-bus addresses other than 0xC00, read 0. Writes to them change nothing.
- R10: An access with address bits 1:0 not equal to 0 reads 0. It is not forwarded, does not write the scratchpad and raises no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slave can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Byte address in the 2 MiB window |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after acceptance |
| rsp_rdata | output | 32 | Read data (0 for writes) |
| ctl_valid | output | 1 | Slave-control sub-port access strobe |
| ctl_write | output | 1 | Sub-port write flag |
| ctl_addr | output | 10 | Sub-port byte address relative to 0x800 |
| ctl_wdata | output | 32 | Sub-port write data |
| ctl_rdata | input | 32 | Sub-port read data, same cycle as `ctl_valid` |
| lbus_rst | output | 1 | One-cycle cold-reset pulse for the local bus |

## Verification
A wrong region decode shows up in the response one cycle after the access: a table, forwarded or scratchpad value appears where zero is expected, or the reverse. A forwarding fault is visible on the sub-port in the accepting cycle itself. A faulty break detector either misses the pulse in the cycle after the magic write or produces a stray one. A corrupted scratchpad is only seen at its next read, so directed reads follow each break write, including a scratchpad write placed back-to-back with the pulse.

// File: rtl/svc_dec_pkg.sv
package svc_dec_pkg;

    localparam int unsigned WORD_W = 32;

    localparam logic [WORD_W-1:0] CHIP_ID_WORD = 32'hC002_2D15;
    localparam logic [WORD_W-1:0] BREAK_WORD   = 32'hC0DE_0000;
    localparam logic [WORD_W-1:0] DESC_MORE    = 32'h8000_0000;
    localparam logic [WORD_W-1:0] DESC_SLOTS   = 32'h0001_0000;

    typedef enum logic [3:0] {
        ENG_PEEK    = 4'd2,
        ENG_LINK    = 4'd3,
        ENG_SCRATCH = 4'd6
    } eng_kind_e;

    typedef struct packed {
        logic [15:0] version;
        eng_kind_e   kind;
        logic [3:0]  chk;
    } eng_desc_t;

    typedef enum logic [1:0] {
        RG_NONE = 2'd0,
        RG_CFG  = 2'd1,
        RG_CTL  = 2'd2,
        RG_LBUS = 2'd3
    } region_e;

    typedef struct packed {
        logic              write;
        logic [WORD_W-1:0] wdata;
    } xfer_t;

    localparam int unsigned NUM_ENG = 3;

    function automatic eng_desc_t eng_entry(input int unsigned i);
        eng_desc_t d;
        case (i)
            0:       d = '{version: 16'h1000, kind: ENG_PEEK,    chk: 4'hC};
            1:       d = '{version: 16'h5000, kind: ENG_LINK,    chk: 4'hA};
            default: d = '{version: 16'h1000, kind: ENG_SCRATCH, chk: 4'h7};
        endcase
        return d;
    endfunction

    function automatic logic [WORD_W-1:0] pack_desc(input eng_desc_t d);
        return DESC_MORE | DESC_SLOTS | {16'b0, d.version}
             | {24'b0, d.kind, 4'b0} | {28'b0, d.chk};
    endfunction

endpackage

// File: rtl/svc_region_decode.sv
module svc_region_decode
    import svc_dec_pkg::*;
#(
    parameter int unsigned ADDR_W   = 21,
    parameter int unsigned CFG_SPAN = 32'h400,
    parameter int unsigned CTL_BASE = 32'h800,
    parameter int unsigned CTL_SPAN = 32'h400,
    parameter int unsigned LB_BASE  = 32'hC00
) (
    input  logic [ADDR_W-1:0] addr,
    output region_e           region,
    output logic [ADDR_W-1:0] offset
);
    localparam logic [ADDR_W-1:0] CFG_END = ADDR_W'(CFG_SPAN);
    localparam logic [ADDR_W-1:0] CTL_LO  = ADDR_W'(CTL_BASE);
    localparam logic [ADDR_W-1:0] CTL_HI  = ADDR_W'(CTL_BASE + CTL_SPAN);
    localparam logic [ADDR_W-1:0] LB_LO   = ADDR_W'(LB_BASE);

    always_comb begin
        region = RG_NONE;
        offset = addr;
        if (addr[1:0] != 2'b00) begin
            region = RG_NONE;
        end else if (addr < CFG_END) begin
            region = RG_CFG;
        end else if (addr >= CTL_LO && addr < CTL_HI) begin
            region = RG_CTL;
            offset = addr - CTL_LO;
        end else if (addr >= LB_LO) begin
            region = RG_LBUS;
            offset = addr - LB_LO;
        end
    end
endmodule

// File: rtl/svc_cfg_table.sv
module svc_cfg_table
    import svc_dec_pkg::*;
#(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned N_ENG = NUM_ENG
) (
    input  logic [IDX_W-1:0]  word_idx,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] desc_words [N_ENG];

    for (genvar g = 0; g < N_ENG; g++) begin : g_desc
        assign desc_words[g] = pack_desc(eng_entry(g));
    end

    always_comb begin
        rdata = '0;
        if (word_idx == '0) begin
            rdata = CHIP_ID_WORD;
        end
        for (int i = 0; i < N_ENG; i++) begin
            if (word_idx == IDX_W'(i + 1)) begin
                rdata = desc_words[i];
            end
        end
    end
endmodule

// File: rtl/svc_break_det.sv
module svc_break_det
    import svc_dec_pkg::*;
#(
    parameter int unsigned IDX_W        = 8,
    parameter int unsigned N_BREAK_WORD = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [IDX_W-1:0]  word_idx,
    input  logic [WORD_W-1:0] wdata,
    output logic              pulse
);
    logic fire;

    assign fire = wr_hit && (word_idx < IDX_W'(N_BREAK_WORD)) && (wdata == BREAK_WORD);

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse <= 1'b0;
        end else begin
            pulse <= fire;
        end
    end
endmodule

// File: rtl/svc_scratch.sv
module svc_scratch
    import svc_dec_pkg::*;
#(
    parameter int unsigned N_REGS = 1,
    parameter int unsigned IDX_W  = 19
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] wdata,
    output logic              sel,
    output logic [WORD_W-1:0] rdata
);
    logic [WORD_W-1:0] regs [N_REGS];

    assign sel = idx < IDX_W'(N_REGS);

    for (genvar g = 0; g < N_REGS; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                regs[g] <= '0;
            end else if (we && idx == IDX_W'(g)) begin
                regs[g] <= wdata;
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < N_REGS; i++) begin
            if (idx == IDX_W'(i)) begin
                rdata = regs[i];
            end
        end
    end
endmodule

// File: rtl/svc_slave_decoder.sv
module svc_slave_decoder
    import svc_dec_pkg::*;
#(
    parameter int unsigned ADDR_W   = 21,
    parameter int unsigned CFG_SPAN = 32'h400,
    parameter int unsigned CTL_BASE = 32'h800,
    parameter int unsigned CTL_SPAN = 32'h400,
    parameter int unsigned LB_BASE  = 32'hC00,
    parameter int unsigned N_SCR    = 1,
    parameter int unsigned CTL_AW   = $clog2(CTL_SPAN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              ctl_valid,
    output logic              ctl_write,
    output logic [CTL_AW-1:0] ctl_addr,
    output logic [31:0]       ctl_wdata,
    input  logic [31:0]       ctl_rdata,
    output logic              lbus_rst
);
    localparam int unsigned CFG_IW = $clog2(CFG_SPAN / 4);
    localparam int unsigned LB_IW  = ADDR_W - 2;

    region_e           region;
    logic [ADDR_W-1:0] offset;
    logic              accept;
    xfer_t             xf;
    logic [WORD_W-1:0] cfg_rdata;
    logic [WORD_W-1:0] scr_rdata;
    logic              scr_sel;
    logic              scr_we;
    logic              cfg_wr;
    logic [WORD_W-1:0] rd_mux;

    assign req_ready = ~rst;
    assign accept    = req_valid && req_ready;
    assign xf        = '{write: req_write, wdata: req_wdata};

    svc_region_decode #(
        .ADDR_W  (ADDR_W),
        .CFG_SPAN(CFG_SPAN),
        .CTL_BASE(CTL_BASE),
        .CTL_SPAN(CTL_SPAN),
        .LB_BASE (LB_BASE)
    ) u_dec (
        .addr  (req_addr),
        .region(region),
        .offset(offset)
    );

    svc_cfg_table #(
        .IDX_W(CFG_IW)
    ) u_cfg (
        .word_idx(offset[CFG_IW+1:2]),
        .rdata   (cfg_rdata)
    );

    assign cfg_wr = accept && xf.write && region == RG_CFG;

    svc_break_det #(
        .IDX_W(CFG_IW)
    ) u_brk (
        .clk     (clk),
        .rst     (rst),
        .wr_hit  (cfg_wr),
        .word_idx(offset[CFG_IW+1:2]),
        .wdata   (xf.wdata),
        .pulse   (lbus_rst)
    );

    assign scr_we = accept && xf.write && region == RG_LBUS && scr_sel;

    svc_scratch #(
        .N_REGS(N_SCR),
        .IDX_W (LB_IW)
    ) u_scr (
        .clk  (clk),
        .rst  (rst),
        .clr  (lbus_rst),
        .we   (scr_we),
        .idx  (offset[ADDR_W-1:2]),
        .wdata(xf.wdata),
        .sel  (scr_sel),
        .rdata(scr_rdata)
    );

    assign ctl_valid = accept && region == RG_CTL;
    assign ctl_write = xf.write;
    assign ctl_addr  = offset[CTL_AW-1:0];
    assign ctl_wdata = xf.wdata;

    always_comb begin
        case (region)
            RG_CFG:  rd_mux = cfg_rdata;
            RG_CTL:  rd_mux = ctl_rdata;
            RG_LBUS: rd_mux = scr_sel ? scr_rdata : '0;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_rdata <= (accept && !xf.write) ? rd_mux : '0;
        end
    end
endmodule

// File: rtl/svc_slave_decoder_chk.sv
module svc_slave_decoder_chk #(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned CTL_AW = 10
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              rsp_valid,
    input logic [31:0]       rsp_rdata,
    input logic              ctl_valid,
    input logic [CTL_AW-1:0] ctl_addr,
    input logic              lbus_rst
);
    logic acc;
    assign acc = req_valid && req_ready;

    // R1
    rst_quiet_chk: assert property (@(posedge clk) rst |=> (!rsp_valid && !lbus_rst));

    // R2
    accept_rsp_chk: assert property (@(posedge clk) disable iff (rst) acc |=> rsp_valid);

    // R2
    idle_rsp_chk: assert property (@(posedge clk) disable iff (rst) !acc |=> !rsp_valid);

    // R2
    wr_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && req_write) |=> rsp_rdata == 32'h0);

    // R3
    chip_id_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !req_write && req_addr == '0) |=> rsp_rdata == 32'hC002_2D15);

    // R6
    brk_fire_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && req_write && (req_addr == ADDR_W'(0) || req_addr == ADDR_W'(4))
         && req_wdata == 32'hC0DE_0000) |=> lbus_rst);

    // R6
    brk_cause_chk: assert property (@(posedge clk) disable iff (rst)
        lbus_rst |-> $past(acc && req_write && req_wdata == 32'hC0DE_0000));

    // R8
    ctl_win_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_valid |-> (req_valid && req_addr >= ADDR_W'(32'h800)
                       && req_addr < ADDR_W'(32'hC00) && req_addr[1:0] == 2'b00
                       && ctl_addr == CTL_AW'(req_addr - ADDR_W'(32'h800))));

    // R9
    unmapped_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && !req_write && req_addr >= ADDR_W'(32'h400) && req_addr < ADDR_W'(32'h800))
        |=> rsp_rdata == 32'h0);

    // R10
    misalign_chk: assert property (@(posedge clk) disable iff (rst)
        (acc && req_addr[1:0] != 2'b00) |=> (rsp_rdata == 32'h0 && !lbus_rst));
endmodule

bind svc_slave_decoder svc_slave_decoder_chk #(
    .ADDR_W(ADDR_W),
    .CTL_AW(CTL_AW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_write(req_write),
    .req_addr (req_addr),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .ctl_valid(ctl_valid),
    .ctl_addr (ctl_addr),
    .lbus_rst (lbus_rst)
);

// File: tb/sim_svc_slave_decoder.sv
`timescale 1ns/1ps
module sim_svc_slave_decoder;
    localparam int AW = 21;
    localparam logic [31:0] BRK = 32'hC0DE_0000;
    localparam logic [31:0] CTL_PAT = 32'h5A00_0000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          ctl_valid;
    logic          ctl_write;
    logic [9:0]    ctl_addr;
    logic [31:0]   ctl_wdata;
    logic [31:0]   ctl_rdata;
    logic          lbus_rst;

    int checks = 0;
    int fails = 0;
    logic [31:0] scr_model = '0;
    bit done = 0;

    always #5 clk = ~clk;

    assign ctl_rdata = CTL_PAT | {22'b0, ctl_addr};

    svc_slave_decoder u0 (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ctl_valid(ctl_valid), .ctl_write(ctl_write), .ctl_addr(ctl_addr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .lbus_rst(lbus_rst)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input logic [AW-1:0] a, input logic [31:0] scr);
        if (a[1:0] != 2'b00) return 32'h0;                    // R10
        if (a < 21'h400) begin
            case (a)
                21'h000: return 32'hC002_2D15;                  // R3
                21'h004: return 32'h8001_102C;                  // R4
                21'h008: return 32'h8001_503A;                  // R4
                21'h00C: return 32'h8001_1067;                  // R4
                default: return 32'h0;                          // R5
            endcase
        end
        if (a < 21'h800) return 32'h0;                         // R9
        if (a < 21'hC00) return CTL_PAT | {22'b0, 10'(a - 21'h800)}; // R8
        return (a == 21'hC00) ? scr : 32'h0;                   // R7 / R9
    endfunction

    function automatic bit is_ctl(input logic [AW-1:0] a);
        return a[1:0] == 2'b00 && a >= 21'h800 && a < 21'hC00;
    endfunction

    task automatic xfer(input bit w, input logic [AW-1:0] a, input logic [31:0] d, input string tag);
        bit brk;
        logic [31:0] exp;
        @(negedge clk);
        chk({tag, " R2 idle no rsp"}, {31'b0, rsp_valid}, 32'h0);
        chk({tag, " R6 pulse one cycle"}, {31'b0, lbus_rst}, 32'h0);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        #1;
        chk({tag, " R8 ctl_valid"}, {31'b0, ctl_valid}, {31'b0, is_ctl(a)});
        if (is_ctl(a)) begin
            chk({tag, " R8 ctl_addr"}, {22'b0, ctl_addr}, {22'b0, 10'(a - 21'h800)});
            chk({tag, " R8 ctl_write"}, {31'b0, ctl_write}, {31'b0, w});
            if (w) chk({tag, " R8 ctl_wdata"}, ctl_wdata, d);
        end
        exp = w ? 32'h0 : exp_read(a, scr_model);
        brk = w && (a == 21'h0 || a == 21'h4) && d == BRK;
        @(negedge clk);
        chk({tag, " R2 rsp_valid"}, {31'b0, rsp_valid}, 32'h1);
        chk({tag, " R2-R10 rsp_rdata"}, rsp_rdata, exp);
        chk({tag, " R6 pulse"}, {31'b0, lbus_rst}, {31'b0, brk});
        if (brk) scr_model = '0;
        else if (w && a == 21'hC00) scr_model = d;
        req_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 ready in reset", {31'b0, req_ready}, 32'h0);
        chk("R1 rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
        chk("R1 lbus_rst in reset", {31'b0, lbus_rst}, 32'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", {31'b0, req_ready}, 32'h1);
        xfer(0, 21'hC00, 0, "R1 scratch");

        // R3 R4 R5 directed table reads
        xfer(0, 21'h000, 0, "R3");
        xfer(0, 21'h004, 0, "R4 peek");
        xfer(0, 21'h008, 0, "R4 link");
        xfer(0, 21'h00C, 0, "R4 scr");
        xfer(0, 21'h010, 0, "R5 first empty");
        xfer(0, 21'h3FC, 0, "R5 last");
        xfer(1, 21'h008, 32'hFFFF_FFFF, "R5 wr");
        xfer(0, 21'h008, 0, "R5 after wr");

        // R7 scratch and R6 break
        xfer(1, 21'hC00, 32'hDEAD_BEEF, "R7 wr");
        xfer(0, 21'hC00, 0, "R7 rd");
        xfer(1, 21'h008, BRK, "R6 wrong word");
        xfer(1, 21'h000, BRK ^ 32'h1, "R6 wrong value");
        xfer(0, 21'hC00, 0, "R6 scratch kept");
        xfer(1, 21'h004, BRK, "R6 word1");
        xfer(0, 21'hC00, 0, "R7 cleared");
        xfer(1, 21'hC00, 32'h1234_5678, "R7 wr2");
        xfer(1, 21'h000, BRK, "R6 word0");
        xfer(0, 21'hC00, 0, "R7 cleared2");

        // R7 clear wins over back-to-back write
        xfer(1, 21'hC00, 32'h0BAD_F00D, "R7 pre");
        @(negedge clk);
        req_valid = 1; req_write = 1; req_addr = 21'h000; req_wdata = BRK;
        @(negedge clk);
        req_addr = 21'hC00; req_wdata = 32'h7777_7777;
        chk("R6 b2b pulse", {31'b0, lbus_rst}, 32'h1);
        @(negedge clk);
        req_valid = 0;
        chk("R6 b2b pulse end", {31'b0, lbus_rst}, 32'h0);
        scr_model = '0;
        xfer(0, 21'hC00, 0, "R7 clear wins");

        // R9 R10
        xfer(1, 21'hC04, 32'h1111_1111, "R9 lb other wr");
        xfer(0, 21'hC04, 0, "R9 lb other rd");
        xfer(0, 21'h500, 0, "R9 hole");
        xfer(1, 21'hC01, 32'h2222_2222, "R10 misaligned scr wr");
        xfer(0, 21'hC00, 0, "R10 scr kept");
        xfer(1, 21'h001, BRK, "R10 misaligned brk");
        xfer(0, 21'h802, 0, "R10 misaligned ctl");
        xfer(1, 21'h800, 32'hABCD_0123, "R8 wr");
        xfer(0, 21'hBFC, 0, "R8 top");

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [AW-1:0] a;
            logic [31:0] d;
            bit w;
            int k;
            k = int'($urandom % 8);
            w = $urandom % 2;
            d = ($urandom % 4 == 0) ? BRK : $urandom;
            case (k)
                0: a = AW'(($urandom % 8) * 4);
                1: a = AW'(($urandom % 2) * 4);
                2: a = AW'(21'h800 + ($urandom % 256) * 4);
                3: a = 21'hC00;
                4: a = AW'(21'hC00 + ($urandom % 1000) * 4);
                5: a = AW'(21'h400 + ($urandom % 256) * 4);
                6: a = AW'($urandom);
                default: a = AW'(($urandom % 16) * 4 + 1 + $urandom % 3);
            endcase
            xfer(w, a, d, "rand");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule